// File: doc/BRIEF.md
# Double to Single Word Converter

This block turns a 64-bit double-precision register image into the 32-bit single-precision word that a single-precision store writes to memory. Most values need no arithmetic. When the exponent is large enough, or when every bit but the sign is zero, the output word is formed by selecting bit fields from the input. Values whose exponent lands in the window that a single-precision denormal can represent take a slower path. That path right-shifts a working fraction one place per clock until the exponent reaches the single-precision minimum, then packs the fraction under a zero exponent field. Every other exponent yields a zero word. No rounding is done anywhere: bits below the kept field are dropped.

A caller presents an operand on `dbl_i` and raises `start_i` for one cycle. `done_o` later pulses for exactly one cycle, and `word_o` carries the result from that cycle until the next result replaces it. A start that arrives while a denormal is still shifting is ignored. A start in the cycle `done_o` is high is accepted, so conversions can run back to back.

Top module: `d2s_convert`

## Requirements
- R1: While `rst_n` is low at a rising edge, `done_o` and `word_o` go to zero.
- R2: Input fields are sign `dbl_i[63]`, biased exponent `dbl_i[62:52]` and fraction `dbl_i[51:0]`; the sign of a direct or denormal result appears in `word_o[31]`.
- R3: When the biased exponent is above 896, `word_o` becomes `{dbl_i[63:62], dbl_i[58:29]}` and `done_o` is high right after the start edge.
- R4: When `dbl_i[62:0]` is all zero, the direct selection of R3 applies, giving `{sign, 31'b0}`.
- R5: When the biased exponent e is in 874..896 and R4 does not apply, `word_o` is `{sign, 8'b0, F}`, where F is bits 51..29 of the 53-bit value `{1'b1, fraction}` shifted right by 897-e with zeros shifted in.
- R6: A denormal result needs 897-e shifts, one per clock (1 to 23), and `done_o` rises after the (897-e)-th rising edge that follows the start edge.
- R7: A nonzero operand whose biased exponent is below 874 gives an all-zero word, sign included, one edge after start.
- R8: `done_o` is high for one cycle per accepted start, and `word_o` does not change while `done_o` is low.
- R9: A `start_i` seen while a denormal shift is in progress is ignored: no extra result is produced and the running conversion is not disturbed.
- R10: A `start_i` in the cycle where `done_o` is high is accepted as a new conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to convert `dbl_i` |
| dbl_i | input | 64 | Double-precision operand, sampled with `start_i` |
| done_o | output | 1 | One-cycle pulse marking a new result |
| word_o | output | 32 | Single-precision result word, held between results |

## Verification
Two events can share a cycle: the last shift of a denormal conversion, which raises `done_o`, and a new `start_i` arriving in that same cycle. The bench drives a fresh direct-path operand exactly in the cycle it sees `done_o` high. It then expects a second `done_o` on the very next cycle carrying the new word, with the denormal word having appeared one cycle earlier. A second test raises `start_i` in the middle of a 23-shift conversion. It expects only the original result and no stray `done_o`.

// File: rtl/d2s_pkg.sv
// Package: shared constants and types for the double-to-single converter.
// Assumes the standard 64-bit and 32-bit floating-point layouts.
package d2s_pkg;
    localparam int DBL_W     = 64;
    localparam int SGL_W     = 32;
    localparam int EXP_W     = 11;
    localparam int FRAC_W    = 52;
    localparam int SFRAC_W   = 23;
    localparam int DN_LO     = 874;   // lowest biased exponent kept as denormal
    localparam int DN_HI     = 896;   // highest biased exponent kept as denormal
    localparam int MAX_SHIFT = DN_HI - DN_LO + 1;
    localparam int CNT_W     = $clog2(MAX_SHIFT + 1);
    localparam int WORK_W    = FRAC_W + 1;

    typedef enum logic [1:0] {
        PATH_ZERO   = 2'd0,
        PATH_DIRECT = 2'd1,
        PATH_DENORM = 2'd2
    } path_e;
endpackage

// File: rtl/d2s_classify.sv
// Module: picks the conversion path from the magnitude bits of the operand
// and, for the denormal path, the number of one-bit right shifts needed.
// Assumes: purely combinational; shifts_o is meaningful only for PATH_DENORM.
module d2s_classify
    import d2s_pkg::*;
(
    input  logic [DBL_W-2:0] mag_i,
    output path_e            path_o,
    output logic [CNT_W-1:0] shifts_o
);
    logic [EXP_W-1:0] exp_b;
    assign exp_b = mag_i[DBL_W-2 -: EXP_W];

    // Purpose: range-compare the biased exponent and derive the shift count.
    always_comb begin
        shifts_o = CNT_W'(EXP_W'(DN_HI + 1) - exp_b);
        if (exp_b > EXP_W'(DN_HI) || mag_i == '0)
            path_o = PATH_DIRECT;
        else if (exp_b >= EXP_W'(DN_LO))
            path_o = PATH_DENORM;
        else
            path_o = PATH_ZERO;
    end

    // Purpose: a denormal request always carries a shift count in 1..MAX_SHIFT.
    always_comb begin
        if (path_o == PATH_DENORM) begin
            assert_shift_range_R6: assert (shifts_o >= CNT_W'(1) && shifts_o <= CNT_W'(MAX_SHIFT));
        end
    end
endmodule

// File: rtl/d2s_shift_engine.sv
// Module: iterative denormalizer. On load it forms {1, fraction} and a shift
// count; then it shifts right by one bit per clock until the count is spent.
// Assumes: load_i is raised only while idle; frac_o is read when last_o is high
// and then equals the fraction field after the final shift.
module d2s_shift_engine
    import d2s_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAC_W-1:0]  frac_i,
    input  logic [CNT_W-1:0]   shifts_i,
    output logic               busy_o,
    output logic               last_o,
    output logic [SFRAC_W-1:0] frac_o
);
    logic [WORK_W-1:0] work_q;
    logic [CNT_W-1:0]  left_q;

    // Purpose: load the working fraction, then shift once per cycle while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
            left_q <= '0;
        end else if (load_i) begin
            work_q <= {1'b1, frac_i};
            left_q <= shifts_i;
        end else if (left_q != '0) begin
            work_q <= work_q >> 1;
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign busy_o = (left_q != '0);
    assign last_o = (left_q == CNT_W'(1));
    // Field after the pending final shift sits one place higher in work_q.
    assign frac_o = work_q[WORK_W-1 -: SFRAC_W];

    assert_shift_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> left_q <= CNT_W'(MAX_SHIFT));

    assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !busy_o);

    assert_lead_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> work_q[WORK_W-1]);
endmodule

// File: rtl/d2s_convert.sv
// Module: top of the double-to-single word converter. Direct and zero results
// are registered one edge after start; denormal results follow after the
// shift engine has finished. Truncates, never rounds.
// Assumes: start_i is ignored while a denormal conversion is in flight.
module d2s_convert
    import d2s_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DBL_W-1:0] dbl_i,
    output logic             done_o,
    output logic [SGL_W-1:0] word_o
);
    path_e               path;
    logic [CNT_W-1:0]    shifts;
    logic                busy;
    logic                last;
    logic [SFRAC_W-1:0]  dn_frac;
    logic                accept;
    logic                sign_q;
    logic                done_q;
    logic [SGL_W-1:0]    word_q;
    logic [SGL_W-1:0]    direct_word;

    d2s_classify u_classify (
        .mag_i    (dbl_i[DBL_W-2:0]),
        .path_o   (path),
        .shifts_o (shifts)
    );

    assign accept      = start_i && !busy;
    assign direct_word = {dbl_i[DBL_W-1 -: 2], dbl_i[DBL_W-6 -: SGL_W-2]};

    d2s_shift_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept && path == PATH_DENORM),
        .frac_i   (dbl_i[FRAC_W-1:0]),
        .shifts_i (shifts),
        .busy_o   (busy),
        .last_o   (last),
        .frac_o   (dn_frac)
    );

    // Purpose: register the result word and the one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            word_q <= '0;
            sign_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                unique case (path)
                    PATH_DIRECT: begin
                        done_q <= 1'b1;
                        word_q <= direct_word;
                    end
                    PATH_ZERO: begin
                        done_q <= 1'b1;
                        word_q <= '0;
                    end
                    default: sign_q <= dbl_i[DBL_W-1];
                endcase
            end
            if (last) begin
                done_q <= 1'b1;
                word_q <= {sign_q, {(SGL_W-1-SFRAC_W){1'b0}}, dn_frac};
            end
        end
    end

    assign done_o = done_q;
    assign word_o = word_q;

    assert_direct_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && dbl_i[62:52] > 11'd896) |=>
        (done_o && word_o == {$past(dbl_i[63:62]), $past(dbl_i[58:29])}));

    assert_zero_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && dbl_i[62:52] < 11'd874 && dbl_i[62:0] != '0) |=>
        (done_o && word_o == '0));

    assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(word_o));

    assert_denorm_exp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(last)) |-> word_o[30:23] == 8'd0);
endmodule

// File: tb/d2s_convert_tb_top.sv
module d2s_convert_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] dbl_i = '0;
    logic        done_o;
    logic [31:0] word_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    d2s_convert dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .dbl_i   (dbl_i),
        .done_o  (done_o),
        .word_o  (word_o)
    );

    typedef struct packed {
        logic [63:0] din;
        logic [31:0] word;
        logic [7:0]  lat;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{64'h3FF0000000000000, 32'h3F800000, 8'd0,  8'd3},  // R3 one
        '{64'h7FF0000000000000, 32'h7F800000, 8'd0,  8'd3},  // R3 infinity
        '{64'h7FF8000000000000, 32'h7FC00000, 8'd0,  8'd3},  // R3 NaN
        '{64'h3810000000000000, 32'h00800000, 8'd0,  8'd3},  // R3 exponent 897
        '{64'hC000000000000000, 32'hC0000000, 8'd0,  8'd2},  // R2 sign on direct
        '{64'h8000000000000000, 32'h80000000, 8'd0,  8'd4},  // R4 negative zero
        '{64'h0000000000000000, 32'h00000000, 8'd0,  8'd4},  // R4 positive zero
        '{64'h3800000000000000, 32'h00400000, 8'd1,  8'd5},  // R5 exponent 896
        '{64'hB7F8000000000000, 32'h80300000, 8'd2,  8'd5},  // R5 negative, 895
        '{64'h36A0000000000000, 32'h00000001, 8'd23, 8'd6},  // R6 exponent 874
        '{64'h36B0000000000000, 32'h00000002, 8'd22, 8'd6},  // R6 exponent 875
        '{64'h3690000000000000, 32'h00000000, 8'd0,  8'd7},  // R7 exponent 873
        '{64'h0000000000000001, 32'h00000000, 8'd0,  8'd7},  // R7 double subnormal
        '{64'h8690000000000000, 32'h00000000, 8'd0,  8'd7}   // R7 sign dropped
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one conversion and return the observed result and latency.
    task automatic run_one(input logic [63:0] din, output logic [31:0] w,
                           output int lat);
        @(negedge clk);
        start_i = 1'b1;
        dbl_i   = din;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        w = word_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w;
        int          lat;
        int          extra;

        repeat (3) @(negedge clk);
        check(done_o == 1'b0 && word_o == 32'h0, "R1",
              {31'b0, done_o, word_o}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_one(VECS[i].din, w, lat);
            check(w == VECS[i].word && lat == int'(VECS[i].lat),
                  $sformatf("R%0d vector %0d", VECS[i].req, i),
                  {w, 24'b0, 8'(lat)}, {VECS[i].word, 24'b0, VECS[i].lat});
        end

        // R8: done lasts one cycle and the word stays put afterwards
        run_one(64'h3FF0000000000000, w, lat);
        @(negedge clk);
        check(done_o == 1'b0 && word_o == 32'h3F800000, "R8",
              {31'b0, done_o, word_o}, {32'h0, 32'h3F800000});

        // R9: start during a 23-shift conversion is ignored
        @(negedge clk);
        start_i = 1'b1;
        dbl_i   = 64'h36A0000000000000;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        start_i = 1'b1;
        dbl_i   = 64'h3FF0000000000000;
        @(negedge clk);
        start_i = 1'b0;
        lat = 3;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 23 && word_o == 32'h00000001, "R9",
              {word_o, 32'(lat)}, {32'h1, 32'd23});
        extra = 0;
        repeat (6) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check(extra == 0 && word_o == 32'h00000001, "R9",
              {32'(extra), word_o}, {32'h0, 32'h1});

        // R10: new start in the cycle done is high is accepted
        @(negedge clk);
        start_i = 1'b1;
        dbl_i   = 64'h3800000000000000;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1 && word_o == 32'h00400000, "R10",
              {31'b0, done_o, word_o}, {31'b0, 1'b1, 32'h00400000});
        start_i = 1'b1;
        dbl_i   = 64'h3FF0000000000000;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1 && word_o == 32'h3F800000, "R10",
              {31'b0, done_o, word_o}, {31'b0, 1'b1, 32'h3F800000});

        // R1: reset mid-stream clears the outputs
        @(negedge clk);
        start_i = 1'b1;
        dbl_i   = 64'h7FF0000000000000;
        @(negedge clk);
        start_i = 1'b0;
        rst_n   = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0 && word_o == 32'h0, "R1",
              {31'b0, done_o, word_o}, 64'h0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule